// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps stores that have executed but not yet committed, in program order, so that the data cache is written only once a store is known to retire. Loads that run out of order look the buffer up in the same cycle. A load receives the data of the youngest buffered store that is older than itself and writes the same word address. If no such store exists, the load is told to use the cache value. A store that is younger than the load is never forwarded, even if its address matches.

Each store carries an age tag and may enter the buffer before its address is known. A load that looks up the buffer while an older store still has no address is recorded in a small watch table. When that store's address later resolves to the load's word, the block reports a load-before-store ordering violation, naming the oldest offending load so that it and everything after it can be replayed. Commit drains one store per cycle from the oldest end. A flush drops every store and watch record younger than a given age.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: `allocReady` is 1, a load gets `fwdHit` 0, a commit gives `drainValid` 0 and `violValid` is 0.
- R2: A commit on a non-empty buffer presents the oldest store on `drainAddr`/`drainData` with `drainValid` 1, in allocation order, one store per cycle. Without `commitValid`, `drainValid` stays 0.
- R3: A load whose word address equals that of a buffered, address-known store that is older than the load gets `fwdHit` 1 and that store's data in the same cycle.
- R4: A store whose address matches but which is younger than the load, or which has the same age, is ignored. With no older match, `fwdHit` is 0.
- R5: When several older stores match, the data comes from the youngest of them.
- R6: With 8 stores held, `allocReady` is 0 and an allocation request is dropped. The buffer never holds more than 8 stores.
- R7: A flush removes every store strictly younger than `flushAge`. Stores of equal or older age remain, and they keep their data and order.
- R8: A load that looks the buffer up while an older store has an unknown address is recorded. When that store's address resolves to the load's word address, `violValid` is 1 in the resolve cycle, with `violAge` giving the load's age. A resolve to a different address reports nothing. A resolved address is then used for forwarding.
- R9: If such a load finds all 4 watch records in use, `loadReplay` is 1 in its lookup cycle.
- R10: Ages wrap modulo 256. Age a is older than age b when bit 7 of (a - b) mod 256 is 1.
- R11: When several recorded loads conflict with the same resolving store, `violAge` is the oldest of them.
- R12: A flush also discards the watch records of loads younger than `flushAge`. This frees their slots, and a later resolve matching such a load's address reports no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Store enters the buffer |
| allocAge | input | 8 | Age tag of the entering store |
| allocAddrKnown | input | 1 | Entering store already has its address |
| allocAddr | input | 16 | Word address of the entering store |
| allocData | input | 32 | Store data |
| allocReady | output | 1 | Buffer can accept a store this cycle |
| resolveValid | input | 1 | A late store address is resolved |
| resolveAge | input | 8 | Age of the store being resolved |
| resolveAddr | input | 16 | Resolved word address |
| loadValid | input | 1 | Load lookup |
| loadAge | input | 8 | Age of the load |
| loadAddr | input | 16 | Word address of the load |
| fwdHit | output | 1 | Forwarded data is valid; otherwise use cache data |
| fwdData | output | 32 | Forwarded store data |
| loadReplay | output | 1 | Load cannot be tracked and must be replayed |
| violValid | output | 1 | Ordering violation found on resolve |
| violAge | output | 8 | Age of the oldest offending load |
| commitValid | input | 1 | Oldest store commits |
| drainValid | output | 1 | Cache write this cycle |
| drainAddr | output | 16 | Cache write word address |
| drainData | output | 32 | Cache write data |
| flushValid | input | 1 | Squash everything younger than flushAge |
| flushAge | input | 8 | Flush boundary age |

## Verification
Forwarding is swept with a full buffer whose store addresses repeat every third entry. Every load age from just before the oldest store to past the youngest is paired with every address, which separates older from younger matches, single from multiple matches, and misses. Separate runs use ages that straddle the wrap point and a flush boundary, so that a compare that ignores wrap-around or flushes inclusively shows up. The ordering check is driven with several loads behind one unknown store. It resolves once to a conflicting address and once to a non-conflicting one, and it fills the watch table to show the replay signal and its release by a flush.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  parameter int DEPTH = 8;
  parameter int WATCH = 4;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 32;
  parameter int AGE_W = 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;
  localparam int W_IDX = $clog2(WATCH);

  typedef logic [AGE_W-1:0] age_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] headIdx;
    logic [DEPTH-1:0] liveMask;
  } sfbStrobe_t;

  // a is older than b under modular (serial) ordering
  function automatic logic isOlder(input age_t a, input age_t b);
    age_t d;
    d = a - b;
    return d[AGE_W-1];
  endfunction
endpackage

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
  import sfb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic allocValid,
  input  logic commitValid,
  input  logic flushValid,
  input  logic [DEPTH-1:0] keepMask,
  output sfbStrobe_t strobe,
  output logic allocReady,
  output logic drainValid
);
  logic [IDX_W-1:0] headIdx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] survivors;
  logic [DEPTH-1:0] liveMask;
  logic full, push, pop;

  assign full = (cnt == CNT_W'(DEPTH));
  assign allocReady = !full && !flushValid;
  assign push = allocValid && allocReady;
  assign pop = commitValid && (cnt != '0);
  assign drainValid = pop;

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    logic [IDX_W-1:0] offset;
    assign offset = SLOT - headIdx;
    assign liveMask[i] = ({1'b0, offset} < cnt);
  end

  assign survivors = CNT_W'($countones(liveMask & keepMask));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      cnt <= '0;
    end else begin
      headIdx <= headIdx + IDX_W'(pop);
      if (flushValid) cnt <= survivors - CNT_W'(pop);
      else cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign strobe.wrEn = push;
  assign strobe.wrIdx = headIdx + cnt[IDX_W-1:0];
  assign strobe.headIdx = headIdx;
  assign strobe.liveMask = liveMask;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(DEPTH)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !commitValid && !flushValid) |=> (cnt == CNT_W'(DEPTH))); // R6
  AST_FLUSH_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (cnt <= $past(cnt))); // R7
endmodule

// File: rtl/sfb_data.sv
module sfb_data
  import sfb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  sfbStrobe_t strobe,
  input  age_t allocAge,
  input  logic allocAddrKnown,
  input  addr_t allocAddr,
  input  data_t allocData,
  input  logic resolveValid,
  input  age_t resolveAge,
  input  addr_t resolveAddr,
  input  age_t loadAge,
  input  addr_t loadAddr,
  input  age_t flushAge,
  output logic [DEPTH-1:0] keepMask,
  output logic [DEPTH-1:0] pendMask,
  output age_t ageArr [DEPTH],
  output logic resolveHit,
  output logic fwdHit,
  output data_t fwdData,
  output logic needWatch,
  output addr_t drainAddr,
  output data_t drainData,
  output logic headKnown
);
  addr_t addrQ [DEPTH];
  data_t dataQ [DEPTH];
  age_t ageQ [DEPTH];
  logic [DEPTH-1:0] knownQ;
  logic [DEPTH-1:0] resolveSel;
  logic [IDX_W-1:0] scanIdx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign keepMask[i] = !isOlder(flushAge, ageQ[i]);
    assign pendMask[i] = strobe.liveMask[i] && !knownQ[i];
    assign resolveSel[i] = resolveValid && pendMask[i] && (ageQ[i] == resolveAge);
    assign ageArr[i] = ageQ[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        knownQ[i] <= 1'b0;
        addrQ[i] <= '0;
        dataQ[i] <= '0;
        ageQ[i] <= '0;
      end else if (strobe.wrEn && strobe.wrIdx == IDX_W'(i)) begin
        knownQ[i] <= allocAddrKnown;
        addrQ[i] <= allocAddr;
        dataQ[i] <= allocData;
        ageQ[i] <= allocAge;
      end else if (resolveSel[i]) begin
        knownQ[i] <= 1'b1;
        addrQ[i] <= resolveAddr;
      end
    end
  end

  assign resolveHit = |resolveSel;

  // scan oldest to youngest; the last qualifying match wins
  always_comb begin
    fwdHit = 1'b0;
    fwdData = '0;
    needWatch = 1'b0;
    scanIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      scanIdx = strobe.headIdx + IDX_W'(k);
      if (strobe.liveMask[scanIdx] && isOlder(ageQ[scanIdx], loadAge)) begin
        if (!knownQ[scanIdx]) needWatch = 1'b1;
        else if (addrQ[scanIdx] == loadAddr) begin
          fwdHit = 1'b1;
          fwdData = dataQ[scanIdx];
        end
      end
    end
  end

  assign drainAddr = addrQ[strobe.headIdx];
  assign drainData = dataQ[strobe.headIdx];
  assign headKnown = knownQ[strobe.headIdx];

  AST_RESOLVE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (resolveHit && !strobe.wrEn) |=> ($countones(pendMask) < $past($countones(pendMask)))); // R8
endmodule

// File: rtl/sfb_watch.sv
module sfb_watch
  import sfb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic loadValid,
  input  age_t loadAge,
  input  addr_t loadAddr,
  input  logic needWatch,
  input  logic [DEPTH-1:0] pendMask,
  input  age_t ageArr [DEPTH],
  input  logic resolveHit,
  input  age_t resolveAge,
  input  addr_t resolveAddr,
  input  logic flushValid,
  input  age_t flushAge,
  output logic loadReplay,
  output logic violValid,
  output age_t violAge
);
  logic [WATCH-1:0] wValid;
  age_t wAge [WATCH];
  addr_t wAddr [WATCH];
  logic [WATCH-1:0] covered;
  logic freeFound;
  logic [W_IDX-1:0] freeIdx;
  logic wantIns;
  logic inCand;

  always_comb begin
    freeFound = 1'b0;
    freeIdx = '0;
    for (int w = WATCH - 1; w >= 0; w--) begin
      if (!wValid[w]) begin
        freeFound = 1'b1;
        freeIdx = W_IDX'(w);
      end
    end
  end

  always_comb begin
    covered = '0;
    for (int w = 0; w < WATCH; w++)
      for (int i = 0; i < DEPTH; i++)
        if (pendMask[i] && isOlder(ageArr[i], wAge[w])) covered[w] = 1'b1;
  end

  assign wantIns = loadValid && needWatch && freeFound &&
                   !(flushValid && isOlder(flushAge, loadAge));
  assign loadReplay = loadValid && needWatch && !freeFound;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wValid <= '0;
      for (int w = 0; w < WATCH; w++) begin
        wAge[w] <= '0;
        wAddr[w] <= '0;
      end
    end else begin
      for (int w = 0; w < WATCH; w++)
        if (wValid[w] && (!covered[w] || (flushValid && isOlder(flushAge, wAge[w]))))
          wValid[w] <= 1'b0;
      if (wantIns) begin
        wValid[freeIdx] <= 1'b1;
        wAge[freeIdx] <= loadAge;
        wAddr[freeIdx] <= loadAddr;
      end
    end
  end

  // a load looking up in the resolve cycle is checked directly
  assign inCand = loadValid && needWatch && resolveHit &&
                  isOlder(resolveAge, loadAge) && (loadAddr == resolveAddr);

  always_comb begin
    violValid = inCand;
    violAge = inCand ? loadAge : '0;
    for (int w = 0; w < WATCH; w++) begin
      if (wValid[w] && resolveHit && isOlder(resolveAge, wAge[w]) && wAddr[w] == resolveAddr &&
          (!violValid || isOlder(wAge[w], violAge))) begin
        violValid = 1'b1;
        violAge = wAge[w];
      end
    end
  end

  AST_VIOL_YOUNGER: assert property (@(posedge clk) disable iff (!rstN)
    violValid |-> isOlder(resolveAge, violAge)); // R8
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
  import sfb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic allocValid,
  input  logic [AGE_W-1:0] allocAge,
  input  logic allocAddrKnown,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic [DATA_W-1:0] allocData,
  output logic allocReady,
  input  logic resolveValid,
  input  logic [AGE_W-1:0] resolveAge,
  input  logic [ADDR_W-1:0] resolveAddr,
  input  logic loadValid,
  input  logic [AGE_W-1:0] loadAge,
  input  logic [ADDR_W-1:0] loadAddr,
  output logic fwdHit,
  output logic [DATA_W-1:0] fwdData,
  output logic loadReplay,
  output logic violValid,
  output logic [AGE_W-1:0] violAge,
  input  logic commitValid,
  output logic drainValid,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  input  logic flushValid,
  input  logic [AGE_W-1:0] flushAge
);
  sfbStrobe_t strobe;
  logic [DEPTH-1:0] keepMask;
  logic [DEPTH-1:0] pendMask;
  age_t ageArr [DEPTH];
  logic resolveHit, hitRaw, needWatch, headKnown;

  sfb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .commitValid(commitValid),
    .flushValid(flushValid), .keepMask(keepMask), .strobe(strobe),
    .allocReady(allocReady), .drainValid(drainValid)
  );

  sfb_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocAge(allocAge),
    .allocAddrKnown(allocAddrKnown), .allocAddr(allocAddr), .allocData(allocData),
    .resolveValid(resolveValid), .resolveAge(resolveAge), .resolveAddr(resolveAddr),
    .loadAge(loadAge), .loadAddr(loadAddr), .flushAge(flushAge),
    .keepMask(keepMask), .pendMask(pendMask), .ageArr(ageArr), .resolveHit(resolveHit),
    .fwdHit(hitRaw), .fwdData(fwdData), .needWatch(needWatch),
    .drainAddr(drainAddr), .drainData(drainData), .headKnown(headKnown)
  );

  sfb_watch u_watch (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadAge(loadAge), .loadAddr(loadAddr),
    .needWatch(needWatch), .pendMask(pendMask), .ageArr(ageArr), .resolveHit(resolveHit),
    .resolveAge(resolveAge), .resolveAddr(resolveAddr), .flushValid(flushValid),
    .flushAge(flushAge), .loadReplay(loadReplay), .violValid(violValid), .violAge(violAge)
  );

  assign fwdHit = loadValid && hitRaw;

  AST_DRAIN_RESOLVED: assert property (@(posedge clk) disable iff (!rstN)
    drainValid |-> headKnown); // R2
endmodule

// File: tb/store_fwd_buffer_test.sv
module store_fwd_buffer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 0, allocAddrKnown = 0;
  logic [7:0] allocAge = 0;
  logic [15:0] allocAddr = 0;
  logic [31:0] allocData = 0;
  logic allocReady;
  logic resolveValid = 0;
  logic [7:0] resolveAge = 0;
  logic [15:0] resolveAddr = 0;
  logic loadValid = 0;
  logic [7:0] loadAge = 0;
  logic [15:0] loadAddr = 0;
  logic fwdHit, loadReplay, violValid;
  logic [31:0] fwdData;
  logic [7:0] violAge;
  logic commitValid = 0;
  logic drainValid;
  logic [15:0] drainAddr;
  logic [31:0] drainData;
  logic flushValid = 0;
  logic [7:0] flushAge = 0;
  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  store_fwd_buffer uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] age, input logic known, input logic [15:0] addr,
                      input logic [31:0] data);
    allocValid = 1; allocAge = age; allocAddrKnown = known; allocAddr = addr; allocData = data;
    @(negedge clk);
    allocValid = 0;
  endtask

  task automatic lookHit(input string tag, input logic [7:0] age, input logic [15:0] addr,
                         input logic hit, input logic [31:0] data, input logic replay);
    loadValid = 1; loadAge = age; loadAddr = addr;
    #1;
    chk(tag, {31'd0, fwdHit}, {31'd0, hit});
    if (hit) chk(tag, fwdData, data);
    chk(tag, {31'd0, loadReplay}, {31'd0, replay});
    @(negedge clk);
    loadValid = 0;
  endtask

  task automatic commitChk(input string tag, input logic valid, input logic [15:0] addr,
                           input logic [31:0] data);
    commitValid = 1;
    #1;
    chk(tag, {31'd0, drainValid}, {31'd0, valid});
    if (valid) begin
      chk(tag, {16'd0, drainAddr}, {16'd0, addr});
      chk(tag, drainData, data);
    end
    @(negedge clk);
    commitValid = 0;
  endtask

  task automatic resolveChk(input string tag, input logic [7:0] age, input logic [15:0] addr,
                            input logic viol, input logic [7:0] vAge);
    resolveValid = 1; resolveAge = age; resolveAddr = addr;
    #1;
    chk(tag, {31'd0, violValid}, {31'd0, viol});
    if (viol) chk(tag, {24'd0, violAge}, {24'd0, vAge});
    @(negedge clk);
    resolveValid = 0;
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1;
    chk("R1 allocReady", {31'd0, allocReady}, 32'd1);
    chk("R1 violValid", {31'd0, violValid}, 32'd0);
    @(negedge clk);
    lookHit("R1 empty lookup", 8'd5, 16'd0, 1'b0, 32'd0, 1'b0);
    commitChk("R1 empty commit", 1'b0, 16'd0, 32'd0);

    // fill: ages 10..17, address k%3, data D000+k
    for (int k = 0; k < 8; k++) begin
      #1;
      chk("R6 ready while filling", {31'd0, allocReady}, 32'd1);
      push(8'(10 + k), 1'b1, 16'(k % 3), 32'hD000 + k);
    end
    allocValid = 1; allocAge = 8'd18; allocAddrKnown = 1; allocAddr = 16'd0; allocData = 32'hBAD;
    #1;
    chk("R6 full blocks", {31'd0, allocReady}, 32'd0);
    @(negedge clk);
    allocValid = 0;

    // forwarding sweep
    for (int la = 9; la <= 19; la++) begin
      for (int a = 0; a < 4; a++) begin
        int best; int nOld; bit young;
        best = -1; nOld = 0; young = 0;
        for (int k = 0; k < 8; k++) begin
          if (k % 3 == a) begin
            if (10 + k < la) begin best = k; nOld++; end
            else young = 1;
          end
        end
        if (nOld > 1) lookHit("R5 youngest older", 8'(la), 16'(a), 1'b1, 32'hD000 + best, 1'b0);
        else if (nOld == 1) lookHit("R3 older fwd", 8'(la), 16'(a), 1'b1, 32'hD000 + best, 1'b0);
        else if (young) lookHit("R4 younger ignored", 8'(la), 16'(a), 1'b0, 32'd0, 1'b0);
        else lookHit("R3 miss", 8'(la), 16'(a), 1'b0, 32'd0, 1'b0);
      end
    end

    // drain in order
    #1;
    chk("R2 no drain without commit", {31'd0, drainValid}, 32'd0);
    for (int k = 0; k < 8; k++) commitChk("R2 drain order", 1'b1, 16'(k % 3), 32'hD000 + k);
    commitChk("R6 dropped store absent", 1'b0, 16'd0, 32'd0);

    // flush: ages 20..25 at address 1, keep 20..22
    for (int k = 0; k < 6; k++) push(8'(20 + k), 1'b1, 16'd1, 32'hF000 + k);
    flushValid = 1; flushAge = 8'd22;
    @(negedge clk);
    flushValid = 0;
    lookHit("R7 flush keeps boundary", 8'd30, 16'd1, 1'b1, 32'hF002, 1'b0);
    for (int k = 0; k < 3; k++) commitChk("R7 survivors drain", 1'b1, 16'd1, 32'hF000 + k);
    commitChk("R7 younger removed", 1'b0, 16'd0, 32'd0);

    // age wrap
    push(8'd254, 1'b1, 16'd5, 32'hA0);
    push(8'd255, 1'b1, 16'd5, 32'hA1);
    push(8'd0, 1'b1, 16'd5, 32'hA2);
    lookHit("R10 wrap youngest older", 8'd1, 16'd5, 1'b1, 32'hA2, 1'b0);
    lookHit("R10 wrap mid", 8'd255, 16'd5, 1'b1, 32'hA0, 1'b0);
    lookHit("R10 wrap none older", 8'd253, 16'd5, 1'b0, 32'd0, 1'b0);
    for (int k = 0; k < 3; k++) commitChk("R10 drain", 1'b1, 16'd5, 32'hA0 + k);

    // ordering violation
    push(8'd40, 1'b0, 16'd0, 32'h4040);
    push(8'd41, 1'b1, 16'd7, 32'h4141);
    lookHit("R8 watched load", 8'd45, 16'd9, 1'b0, 32'd0, 1'b0);
    lookHit("R8 watched load", 8'd47, 16'd9, 1'b0, 32'd0, 1'b0);
    lookHit("R8 watched load", 8'd43, 16'd3, 1'b0, 32'd0, 1'b0);
    resolveChk("R11 oldest violator", 8'd40, 16'd9, 1'b1, 8'd45);
    lookHit("R8 resolved addr forwards", 8'd48, 16'd9, 1'b1, 32'h4040, 1'b0);
    push(8'd50, 1'b0, 16'd0, 32'h5050);
    lookHit("R8 watched load", 8'd52, 16'd8, 1'b0, 32'd0, 1'b0);
    resolveChk("R8 no overlap", 8'd50, 16'd2, 1'b0, 8'd0);
    commitChk("R8 drain", 1'b1, 16'd9, 32'h4040);
    commitChk("R8 drain", 1'b1, 16'd7, 32'h4141);
    commitChk("R8 drain", 1'b1, 16'd2, 32'h5050);

    // watch table full, then flush frees records
    push(8'd60, 1'b0, 16'd0, 32'h6060);
    for (int k = 1; k <= 4; k++) lookHit("R9 slot free", 8'(60 + k), 16'(16 + k), 1'b0, 32'd0, 1'b0);
    lookHit("R9 table full replay", 8'd65, 16'd21, 1'b0, 32'd0, 1'b1);
    flushValid = 1; flushAge = 8'd62;
    @(negedge clk);
    flushValid = 0;
    lookHit("R12 slot released", 8'd63, 16'd4, 1'b0, 32'd0, 1'b0);
    resolveChk("R12 flushed load not flagged", 8'd60, 16'd20, 1'b0, 8'd0);
    commitChk("R7 older store survives", 1'b1, 16'd20, 32'h6060);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule